// File: doc/BRIEF.md
# Memory-Mapped to PCI Express Address Translator

This block sits behind the slave side of a memory-mapped bus and turns each outgoing bus address into a PCI Express address. The incoming address is cut at bit position N. The bits below that cut pass straight through. The bits from N up to the top of the slave address form a page number. That page number picks one entry in a small programmable table. The entry supplies the upper PCI Express address bits and a 2-bit code that names the target address space. Both the translated address and the code are registered, so they appear one clock after the request.

Software fills the table through a control port that is separate from the data path. The control port has one write channel and one read-back channel. A write changes an entry from the next clock onward. A read returns the entry's base and space code one clock later. Reset clears every entry, so an untouched page translates to address zero in the 32-bit memory space.

The space code is 2'b00 for 32-bit memory, 2'b01 for 64-bit memory and 2'b10 for I/O. The value 2'b11 is reserved and is translated like 64-bit memory. For the 32-bit memory code, the output bits from 32 upward are forced to zero.

Top module: `mm2pcie_xlate`

## Requirements
- R1: Bits N-1..0 of `out_addr` equal bits N-1..0 of the `in_addr` that was accepted one cycle earlier (N = LOW_W, default 20).
- R2: Bits M-1..N of `in_addr` select table entry idx, with Q = 2^(M-N) entries (default 16). For a space code other than 2'b00, `out_addr[P-1:N]` equals that entry's stored base.
- R3: `out_space` equals the 2-bit space code stored in the selected entry. The encodings are 00 = 32-bit memory, 01 = 64-bit memory, 10 = I/O and 11 = reserved, which is passed through unchanged.
- R4: When the selected entry's space code is 2'b00, `out_addr[P-1:32]` is zero, while `out_addr[31:N]` still comes from the entry's base.
- R5: `out_valid` is `in_valid` delayed by one clock. While `out_valid` is low, `out_addr` and `out_space` hold their previous values.
- R6: A write with `cfg_we` high stores `cfg_wbase` and `cfg_wspace` into entry `cfg_widx` at the clock edge. A translation in that same cycle sees the old contents, and a translation in the next cycle sees the new contents.
- R7: While `rst` is high, `out_valid` and `cfg_rvalid` are driven low. After reset, every entry holds base 0 and space code 00.
- R8: When `cfg_re` is high, `cfg_rvalid` is high on the next cycle, and `cfg_rbase`/`cfg_rspace` hold entry `cfg_ridx`. In other cycles `cfg_rvalid` is low.
- R9: A read-back in the same cycle as a write to the same entry returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Slave address is valid this cycle |
| in_addr | input | M (24) | Slave-side address |
| out_valid | output | 1 | Translated address is valid |
| out_addr | output | P (64) | Translated PCI Express address |
| out_space | output | 2 | Space code of the selected entry |
| cfg_we | input | 1 | Table write strobe |
| cfg_widx | input | M-N (4) | Entry to write |
| cfg_wbase | input | P-N (44) | Upper address bits to store |
| cfg_wspace | input | 2 | Space code to store |
| cfg_re | input | 1 | Table read strobe |
| cfg_ridx | input | M-N (4) | Entry to read |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rbase | output | P-N (44) | Stored upper bits of the read entry |
| cfg_rspace | output | 2 | Stored space code of the read entry |

## Verification
The assertions assume that reset is held for at least one clock before any check counts. They also assume that every input is a known value at each rising edge, because the valid and hold relations compare the samples from one cycle with the next. The bench drives all inputs on the falling edge and keeps them at defined values, including the don't-care fields while a strobe is low. Random writes, reads and translations are allowed to hit the same entry in the same cycle. The read-before-write ordering is therefore exercised rather than avoided.

// File: rtl/mm2pcie_pkg.sv
package mm2pcie_pkg;

  typedef enum logic [1:0] {
    SP_MEM32 = 2'b00,
    SP_MEM64 = 2'b01,
    SP_IO    = 2'b10,
    SP_RSVD  = 2'b11
  } space_e;

  function automatic logic clears_high(input logic [1:0] code);
    return code == SP_MEM32;
  endfunction

endpackage

// File: rtl/mm2pcie_addr_split.sv
module mm2pcie_addr_split #(
  parameter int M_W   = 24,
  parameter int LOW_W = 20,
  localparam int IDX_W = M_W - LOW_W
) (
  input  logic [M_W-1:0]   addr,
  output logic [IDX_W-1:0] page_idx,
  output logic [LOW_W-1:0] page_off
);

  // The page number selects a table entry; the offset passes through.
  assign page_idx = addr[M_W-1:LOW_W];
  assign page_off = addr[LOW_W-1:0];

endmodule

// File: rtl/mm2pcie_xlate_table.sv
module mm2pcie_xlate_table #(
  parameter int IDX_W  = 4,
  parameter int BASE_W = 44,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [1:0]        wr_space,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [BASE_W-1:0] lk_base,
  output logic [1:0]        lk_space,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [1:0]        rd_space
);

  logic [BASE_W-1:0] base_q  [ENTRIES];
  logic [1:0]        space_q [ENTRIES];

  // Each entry is a register with its own reset, so reset clears the table.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[e]  <= '0;
        space_q[e] <= 2'b00;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        base_q[e]  <= wr_base;
        space_q[e] <= wr_space;
      end
    end
  end

  // Asynchronous reads see the contents from before a same-cycle write.
  assign lk_base  = base_q[lk_idx];
  assign lk_space = space_q[lk_idx];
  assign rd_base  = base_q[rd_idx];
  assign rd_space = space_q[rd_idx];

endmodule

// File: rtl/mm2pcie_out_stage.sv
module mm2pcie_out_stage
  import mm2pcie_pkg::*;
#(
  parameter int P_W   = 64,
  parameter int LOW_W = 20,
  localparam int BASE_W = P_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LOW_W-1:0]  page_off,
  input  logic [BASE_W-1:0] base,
  input  logic [1:0]        space,
  output logic              out_valid,
  output logic [P_W-1:0]    out_addr,
  output logic [1:0]        out_space
);

  logic [P_W-1:0] joined;
  logic [P_W-1:0] shaped;

  assign joined = {base, page_off};

  // The high-half clear exists only when the address is wider than 32 bits.
  if (P_W > 32) begin : g_wide
    always_comb begin
      shaped = joined;
      if (clears_high(space)) shaped[P_W-1:32] = '0;
    end
  end else begin : g_narrow
    assign shaped = joined;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // The data registers load only on a valid request and hold otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr  <= '0;
      out_space <= 2'b00;
    end else if (in_valid) begin
      out_addr  <= shaped;
      out_space <= space;
    end
  end

endmodule

// File: rtl/mm2pcie_cfg_port.sv
module mm2pcie_cfg_port #(
  parameter int BASE_W = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic [BASE_W-1:0] tbl_base,
  input  logic [1:0]        tbl_space,
  output logic              rvalid,
  output logic [BASE_W-1:0] rbase,
  output logic [1:0]        rspace
);

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbase  <= '0;
      rspace <= 2'b00;
    end else if (re) begin
      rbase  <= tbl_base;
      rspace <= tbl_space;
    end
  end

endmodule

// File: rtl/mm2pcie_xlate.sv
module mm2pcie_xlate #(
  parameter int LOW_W = 20,
  parameter int M_W   = 24,
  parameter int P_W   = 64,
  localparam int IDX_W  = M_W - LOW_W,
  localparam int BASE_W = P_W - LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [M_W-1:0]    in_addr,
  output logic              out_valid,
  output logic [P_W-1:0]    out_addr,
  output logic [1:0]        out_space,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_widx,
  input  logic [BASE_W-1:0] cfg_wbase,
  input  logic [1:0]        cfg_wspace,
  input  logic              cfg_re,
  input  logic [IDX_W-1:0]  cfg_ridx,
  output logic              cfg_rvalid,
  output logic [BASE_W-1:0] cfg_rbase,
  output logic [1:0]        cfg_rspace
);

  logic [IDX_W-1:0]  page_idx;
  logic [LOW_W-1:0]  page_off;
  logic [BASE_W-1:0] lk_base;
  logic [1:0]        lk_space;
  logic [BASE_W-1:0] rd_base;
  logic [1:0]        rd_space;

  mm2pcie_addr_split #(.M_W(M_W), .LOW_W(LOW_W)) split_i (
    .addr     (in_addr),
    .page_idx (page_idx),
    .page_off (page_off)
  );

  mm2pcie_xlate_table #(.IDX_W(IDX_W), .BASE_W(BASE_W)) table_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_widx),
    .wr_base  (cfg_wbase),
    .wr_space (cfg_wspace),
    .lk_idx   (page_idx),
    .lk_base  (lk_base),
    .lk_space (lk_space),
    .rd_idx   (cfg_ridx),
    .rd_base  (rd_base),
    .rd_space (rd_space)
  );

  mm2pcie_out_stage #(.P_W(P_W), .LOW_W(LOW_W)) out_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .page_off  (page_off),
    .base      (lk_base),
    .space     (lk_space),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_space (out_space)
  );

  mm2pcie_cfg_port #(.BASE_W(BASE_W)) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .re        (cfg_re),
    .tbl_base  (rd_base),
    .tbl_space (rd_space),
    .rvalid    (cfg_rvalid),
    .rbase     (cfg_rbase),
    .rspace    (cfg_rspace)
  );

endmodule

// File: rtl/mm2pcie_xlate_chk.sv
module mm2pcie_xlate_chk #(
  parameter int LOW_W = 20,
  parameter int M_W   = 24,
  parameter int P_W   = 64
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [M_W-1:0] in_addr,
  input logic           out_valid,
  input logic [P_W-1:0] out_addr,
  input logic [1:0]     out_space,
  input logic           cfg_re,
  input logic           cfg_rvalid
);

  // R7: reset drives both valid outputs low.
  p_reset_idle_r7: assert property (@(posedge clk)
    rst |=> (!out_valid && !cfg_rvalid));

  // R5: the valid output follows the valid input one cycle later.
  p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R5: the outputs hold when no request was accepted.
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(out_addr) && $stable(out_space)));

  // R1: the offset bits pass through unchanged.
  p_low_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> (out_addr[LOW_W-1:0] == $past(in_addr[LOW_W-1:0])));

  // R4: the 32-bit memory space code forces the upper half to zero.
  if (P_W > 32) begin : g_hi
    p_mem32_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_space == 2'b00) |-> (out_addr[P_W-1:32] == '0));
  end

  // R8: the read strobe produces a read-valid pulse on the next cycle.
  p_rvalid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cfg_rvalid == $past(cfg_re)));

endmodule

bind mm2pcie_xlate mm2pcie_xlate_chk #(.LOW_W(LOW_W), .M_W(M_W), .P_W(P_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_addr    (in_addr),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .out_space  (out_space),
  .cfg_re     (cfg_re),
  .cfg_rvalid (cfg_rvalid)
);

// File: tb/mm2pcie_xlate_tb_top.sv
`timescale 1ns/1ps
module mm2pcie_xlate_tb_top;

  localparam int LOW_W  = 20;
  localparam int M_W    = 24;
  localparam int P_W    = 64;
  localparam int IDX_W  = M_W - LOW_W;
  localparam int BASE_W = P_W - LOW_W;
  localparam int NENT   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [M_W-1:0]    in_addr = '0;
  logic              out_valid;
  logic [P_W-1:0]    out_addr;
  logic [1:0]        out_space;
  logic              cfg_we = 1'b0;
  logic [IDX_W-1:0]  cfg_widx = '0;
  logic [BASE_W-1:0] cfg_wbase = '0;
  logic [1:0]        cfg_wspace = '0;
  logic              cfg_re = 1'b0;
  logic [IDX_W-1:0]  cfg_ridx = '0;
  logic              cfg_rvalid;
  logic [BASE_W-1:0] cfg_rbase;
  logic [1:0]        cfg_rspace;

  always #5 clk = ~clk;

  mm2pcie_xlate #(.LOW_W(LOW_W), .M_W(M_W), .P_W(P_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_space(out_space),
    .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wbase(cfg_wbase),
    .cfg_wspace(cfg_wspace), .cfg_re(cfg_re), .cfg_ridx(cfg_ridx),
    .cfg_rvalid(cfg_rvalid), .cfg_rbase(cfg_rbase), .cfg_rspace(cfg_rspace)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [BASE_W-1:0] m_base  [NENT];
  logic [1:0]        m_space [NENT];
  logic [P_W-1:0]    prev_addr;
  logic [1:0]        prev_space;

  function automatic logic [P_W-1:0] exp_addr(input logic [M_W-1:0] a,
                                              input logic [BASE_W-1:0] b,
                                              input logic [1:0] s);
    logic [P_W-1:0] r;
    r = {b, a[LOW_W-1:0]};
    if (s == 2'b00) r[P_W-1:32] = '0;
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [P_W-1:0] act, input logic [P_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, predict from the old table,
  // sample just after the rising edge, then commit the write to the model.
  task automatic cycle(input bit v, input logic [M_W-1:0] a,
                       input bit we, input logic [IDX_W-1:0] wi,
                       input logic [BASE_W-1:0] wb, input logic [1:0] ws,
                       input bit re, input logic [IDX_W-1:0] ri);
    logic [IDX_W-1:0] pi;
    logic [P_W-1:0]   ea;
    logic [1:0]       es;
    @(negedge clk);
    in_valid = v; in_addr = a;
    cfg_we = we; cfg_widx = wi; cfg_wbase = wb; cfg_wspace = ws;
    cfg_re = re; cfg_ridx = ri;
    pi = a[M_W-1:LOW_W];
    ea = exp_addr(a, m_base[pi], m_space[pi]);
    es = m_space[pi];
    prev_addr = out_addr; prev_space = out_space;
    @(posedge clk); #1;
    check(out_valid == v, "R5 out_valid", P_W'(out_valid), P_W'(v));
    if (v) begin
      check(out_addr[LOW_W-1:0] == ea[LOW_W-1:0], "R1 low bits",
            out_addr, ea);
      check(out_addr == ea, "R2/R4/R6 translated address", out_addr, ea);
      check(out_space == es, "R3 space code", P_W'(out_space), P_W'(es));
    end else begin
      check(out_addr == prev_addr && out_space == prev_space, "R5 hold",
            out_addr, prev_addr);
    end
    check(cfg_rvalid == re, "R8 rvalid", P_W'(cfg_rvalid), P_W'(re));
    if (re) begin
      check(cfg_rbase == m_base[ri] && cfg_rspace == m_space[ri],
            "R8/R9 read-back", {cfg_rspace, cfg_rbase},
            {m_space[ri], m_base[ri]});
    end
    if (we) begin
      m_base[wi] = wb; m_space[wi] = ws;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [BASE_W-1:0] big;
    void'($urandom(32'd1234));
    for (int i = 0; i < NENT; i++) begin
      m_base[i] = '0; m_space[i] = 2'b00;
    end
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && !cfg_rvalid, "R7 valids low in reset",
          P_W'({out_valid, cfg_rvalid}), '0);
    @(negedge clk); rst = 1'b0;

    // R7: table cleared, entry 5 reads and translates as zero.
    cycle(1, 24'h5ABCDE, 0, '0, '0, 2'b00, 1, 4'd5);
    // R6: write entry 3 while translating page 3: old contents used.
    big = 44'hABC_1234_5678;
    cycle(1, 24'h312345, 1, 4'd3, big, 2'b01, 0, '0);
    cycle(1, 24'h312345, 0, '0, '0, 2'b00, 0, '0);
    // R9: read and write entry 7 in one cycle, then read again.
    cycle(0, '0, 1, 4'd7, 44'h111_2222_3333, 2'b10, 1, 4'd7);
    cycle(0, '0, 0, '0, '0, 2'b00, 1, 4'd7);
    // R4: 32-bit memory code on a base with upper bits set.
    cycle(0, '0, 1, 4'd15, 44'hFFF_FFFF_FFFF, 2'b00, 0, '0);
    cycle(1, 24'hFFFFFF, 0, '0, '0, 2'b00, 0, '0);
    // R3: reserved code is passed through; page 0 boundary.
    cycle(0, '0, 1, 4'd0, 44'h800_0000_0001, 2'b11, 0, '0);
    cycle(1, 24'h000000, 0, '0, '0, 2'b00, 1, 4'd0);

    // Random mix of translations, writes and reads.
    for (int k = 0; k < 400; k++) begin
      cycle($urandom_range(0, 1) == 1, M_W'($urandom),
            $urandom_range(0, 3) == 0, IDX_W'($urandom),
            {12'($urandom), 32'($urandom)}, 2'($urandom),
            $urandom_range(0, 2) == 0, IDX_W'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule